// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 4 Kbit serial EEPROM that a host drives over three wires: a select line, a serial clock and a data input, with a data output that the block drives only when it has something to say. The host frames each command as a start bit, a two-bit opcode and an address. It can then read a stored word, write one, erase one, or switch write protection on or off. All serial inputs are oversampled in the system clock domain. A parameter chooses an array of 512 bytes or one of 256 sixteen-bit words, and that choice also sets the widths of the address and data fields.

Write and erase do not finish while the host is clocking. The command is held until the select line falls. At that point a programming cycle starts, and an internal counter times it in system clocks; the serial clock plays no part in it. A write replaces the old contents in a single store, so no erase is needed first. If the host selects the device while the cycle is still running, the data output gives the state of the cycle: low while it runs and high once it has finished. Commands sent during the cycle have no effect. A select that follows a deselect too quickly is refused for the whole of that select period.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data output is released (enable low), no programming cycle is running, and writes are disabled.
- R2: A command opens on the first rising serial clock edge that samples a 1 while the device is selected. Edges that sample 0 before it are ignored. Next come two opcode bits (10 read, 01 write, 11 erase, 00 extended group) and then the address, MSB first: 9 bits for the byte array and 8 bits for the word array.
- R3: In the extended group, the two address MSBs select the action: 11 enables writes and 00 disables them. The other two patterns change nothing.
- R4: A read drives a 0 on the data output after the last address bit. Each following rising serial clock edge then presents the next data bit, MSB first. The rising edge after the last data bit releases the output.
- R5: A write takes one data word, MSB first, after the address. The falling edge of select starts the store, and the stored word fully replaces the previous contents.
- R6: An erase sets every bit of the addressed word to 1.
- R7: While writes are disabled, write and erase commands start no cycle and leave the memory unchanged.
- R8: A programming cycle lasts PROG_CYCLES system clocks with no serial clock needed. The memory is updated as the cycle ends.
- R9: If the device is selected while a cycle runs, the data output is driven low until the cycle ends and high afterwards. It is released when select falls.
- R10: A command sent while a cycle runs returns no read data and starts no new cycle.
- R11: A select that begins fewer than CS_MIN system clocks after the deselect, as seen after input synchronization, is ignored until the next deselect. The data output stays released during it.
- R12: A write whose data word is cut short by the falling edge of select starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i_sel | input | 1 | Device select, active high |
| i_sclk | input | 1 | Serial clock from the host |
| i_sdin | input | 1 | Serial data from the host |
| o_sdout | output | 1 | Serial data or status toward the host |
| o_sdout_en | output | 1 | Drive enable for o_sdout; low means high impedance |

## Verification
A decoder that loses its place in the bit count shows up within one serial clock period after the address: the dummy zero appears early or late, or read data comes back shifted by one bit. A corrupted write-enable flag or cycle timer is visible at the next select. The status level is either missing or sits on the wrong side of the PROG_CYCLES boundary, and both boundary sides are sampled with a margin of tens of clocks. An ignored command that leaks into the state is caught by the following select or read-back, because the memory or the ready level then differs from the value the bench predicts.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_RDOUT,
    ST_HOLD,
    ST_STATUS,
    ST_REJECT
  } mw_state_t;

endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CTW = $clog2(CYCLES + 1);

  logic [CTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy) begin
        if (cnt_q == CTW'(CYCLES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8: an accepted start always opens a busy window
  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8: completion is only flagged once the window has closed
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int DW    = 8,
  parameter int AW    = 9,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_r [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_r[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem_r[waddr] <= wdata;
    rdata <= mem_r[raddr];
  end
endmodule

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int AW     = 9,
  parameter int DW     = 8,
  parameter int CS_MIN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sk_s,
  input  logic          di_s,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          prog_start,
  output logic          prog_erase,
  output logic          do_val,
  output logic          do_en
);
  localparam int MAXB = (AW > DW) ? AW : DW;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int DCW  = $clog2(CS_MIN + 1);

  mw_state_t      st_q;
  mw_op_t         opc_q;
  logic [CW-1:0]  bit_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q, sh_q;
  logic [DCW-1:0] dsel_q;
  logic cs_d, sk_d, pend_wr_q, pend_er_q, wen_q;
  logic do_q, doe_q, start_q, erase_q;

  logic          cs_rise, cs_fall, sk_rise;
  logic [AW-1:0] addr_nx;

  assign cs_rise = cs_s & ~cs_d;
  assign cs_fall = ~cs_s & cs_d;
  assign sk_rise = sk_s & ~sk_d;
  assign addr_nx = {addr_q[AW-2:0], di_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      opc_q     <= OP_EXT;
      bit_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      sh_q      <= '0;
      dsel_q    <= DCW'(CS_MIN);
      cs_d      <= 1'b0;
      sk_d      <= 1'b0;
      pend_wr_q <= 1'b0;
      pend_er_q <= 1'b0;
      wen_q     <= 1'b0;
      do_q      <= 1'b0;
      doe_q     <= 1'b0;
      start_q   <= 1'b0;
      erase_q   <= 1'b0;
    end else begin
      cs_d    <= cs_s;
      sk_d    <= sk_s;
      start_q <= 1'b0;

      if (cs_s) dsel_q <= '0;
      else if (dsel_q != DCW'(CS_MIN)) dsel_q <= dsel_q + 1'b1;

      if (cs_fall) begin
        st_q      <= ST_IDLE;
        doe_q     <= 1'b0;
        pend_wr_q <= 1'b0;
        pend_er_q <= 1'b0;
        if (st_q == ST_HOLD && (pend_wr_q || pend_er_q) && wen_q && !busy) begin
          start_q <= 1'b1;
          erase_q <= pend_er_q;
        end
      end else if (!cs_s) begin
        st_q  <= ST_IDLE;
        doe_q <= 1'b0;
      end else if (cs_rise) begin
        if (dsel_q != DCW'(CS_MIN)) begin
          st_q <= ST_REJECT;
        end else if (busy) begin
          st_q  <= ST_STATUS;
          doe_q <= 1'b1;
          do_q  <= 1'b0;
        end else begin
          st_q <= ST_IDLE;
        end
      end else begin
        unique case (st_q)
          ST_STATUS: begin
            do_q <= !busy;
            if (!busy && sk_rise && di_s) begin
              st_q      <= ST_OPC;
              doe_q     <= 1'b0;
              bit_q     <= '0;
              pend_wr_q <= 1'b0;
              pend_er_q <= 1'b0;
            end
          end
          ST_IDLE: begin
            if (sk_rise && di_s) begin
              st_q      <= ST_OPC;
              bit_q     <= '0;
              pend_wr_q <= 1'b0;
              pend_er_q <= 1'b0;
            end
          end
          ST_OPC: begin
            if (sk_rise) begin
              opc_q <= mw_op_t'({opc_q[0], di_s});
              if (bit_q == CW'(1)) begin
                st_q  <= ST_ADDR;
                bit_q <= '0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          ST_ADDR: begin
            if (sk_rise) begin
              addr_q <= addr_nx;
              if (bit_q == CW'(AW - 1)) begin
                bit_q <= '0;
                unique case (opc_q)
                  OP_READ: begin
                    st_q  <= ST_RDOUT;
                    doe_q <= 1'b1;
                    do_q  <= 1'b0;
                  end
                  OP_WRITE: st_q <= ST_DATA;
                  OP_ERASE: begin
                    st_q      <= ST_HOLD;
                    pend_er_q <= 1'b1;
                  end
                  OP_EXT: begin
                    st_q <= ST_HOLD;
                    if (addr_nx[AW-1:AW-2] == 2'b11) wen_q <= 1'b1;
                    else if (addr_nx[AW-1:AW-2] == 2'b00) wen_q <= 1'b0;
                  end
                endcase
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (sk_rise) begin
              data_q <= {data_q[DW-2:0], di_s};
              if (bit_q == CW'(DW - 1)) begin
                st_q      <= ST_HOLD;
                pend_wr_q <= 1'b1;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          ST_RDOUT: begin
            if (sk_rise) begin
              if (bit_q == '0) begin
                do_q  <= rd_data[DW-1];
                sh_q  <= rd_data << 1;
                bit_q <= CW'(1);
              end else if (bit_q == CW'(DW)) begin
                doe_q <= 1'b0;
                st_q  <= ST_HOLD;
              end else begin
                do_q  <= sh_q[DW-1];
                sh_q  <= sh_q << 1;
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          ST_HOLD, ST_REJECT: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cmd_addr   = addr_q;
  assign cmd_data   = data_q;
  assign prog_start = start_q;
  assign prog_erase = erase_q;
  assign do_val     = do_q;
  assign do_en      = doe_q;

  // R9: a deselected device lets go of the data line on the next clock
  p_release_desel_r9: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !doe_q);
  // R9: while the timer still runs, the status level shown is low
  p_status_low_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STATUS && cs_s && busy) |=> (doe_q && !do_q));
  // R11: a refused select never drives the line nor starts a cycle
  p_reject_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REJECT) |-> (!doe_q && !start_q));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ORG16       = 0,
  parameter int MEM_BITS    = 4096,
  parameter int PROG_CYCLES = 400,
  parameter int CS_MIN      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic i_sel,
  input  logic i_sclk,
  input  logic i_sdin,
  output logic o_sdout,
  output logic o_sdout_en
);
  localparam int DW    = (ORG16 != 0) ? 16 : 8;
  localparam int DEPTH = MEM_BITS / DW;
  localparam int AW    = $clog2(DEPTH);

  logic [2:0]    pins_s;
  logic [AW-1:0] cmd_addr, lat_addr;
  logic [DW-1:0] cmd_data, lat_wdata, rd_data;
  logic          prog_start, prog_erase, busy, done;

  mw_in_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({i_sel, i_sclk, i_sdin}),
    .q   (pins_s)
  );

  mw_cmd_decoder #(.AW(AW), .DW(DW), .CS_MIN(CS_MIN)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .cs_s       (pins_s[2]),
    .sk_s       (pins_s[1]),
    .di_s       (pins_s[0]),
    .busy       (busy),
    .rd_data    (rd_data),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .prog_start (prog_start),
    .prog_erase (prog_erase),
    .do_val     (o_sdout),
    .do_en      (o_sdout_en)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (prog_start),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (prog_start && !busy) begin
      lat_addr  <= cmd_addr;
      lat_wdata <= prog_erase ? '1 : cmd_data;
    end
  end

  mw_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (done),
    .waddr (lat_addr),
    .wdata (lat_wdata),
    .raddr (cmd_addr),
    .rdata (rd_data)
  );

  // R10: the decoder never asks for a cycle while one is running
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !prog_start);
  // R8: the array is only written right after a timed window
  p_store_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb_top;
  localparam int PROG = 400;
  localparam int CSM  = 8;
  localparam int DW   = 8;
  localparam int AW   = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_en;
  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  mw_eeprom #(.ORG16(0), .PROG_CYCLES(PROG), .CS_MIN(CSM)) dut_i (
    .clk(clk), .rst(rst), .i_sel(sel), .i_sclk(sclk), .i_sdin(sdin),
    .o_sdout(sdout), .o_sdout_en(sdout_en)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdin = b; wt(3); sclk = 1'b1; wt(6); sclk = 1'b0; wt(3);
  endtask

  task automatic take_bit(output logic b);
    sdin = 1'b0; wt(3); sclk = 1'b1; wt(6); b = sdout; sclk = 1'b0; wt(3);
  endtask

  task automatic select_dev();
    sel = 1'b1; wt(4);
  endtask

  task automatic deselect_dev();
    sel = 1'b0; sdin = 1'b0; wt(20);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a);
    send_bit(1'b1);
    send_bit(op[1]); send_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_word(input logic [DW-1:0] d, input int nbits);
    for (int i = DW - 1; i >= DW - nbits; i--) send_bit(d[i]);
  endtask

  task automatic ext_cmd(input logic [1:0] msbs);
    select_dev(); send_cmd(2'b00, {msbs, 7'b0}); deselect_dev();
  endtask

  task automatic read_word(input logic [AW-1:0] a, input int lead, output logic [DW-1:0] v);
    logic b;
    select_dev();
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    send_cmd(2'b10, a);
    chk("R4 dummy zero after address", {14'b0, sdout_en, sdout}, 16'b10);
    for (int i = DW - 1; i >= 0; i--) begin
      take_bit(b);
      v[i] = b;
    end
    take_bit(b);
    chk("R4 output released after last bit", {15'b0, sdout_en}, 16'b0);
    deselect_dev();
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    select_dev(); send_cmd(2'b01, a); send_word(d, DW); deselect_dev(); wt(PROG + 50);
  endtask

  task automatic expect_idle(input string req);
    select_dev(); wt(2);
    chk(req, {15'b0, sdout_en}, 16'b0);
    deselect_dev();
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 output released after reset", {15'b0, sdout_en}, 16'b0);
    select_dev(); send_cmd(2'b01, 9'd7); send_word(8'h12, DW); deselect_dev();
    expect_idle("R1 writes disabled after reset, no cycle");
    read_word(9'd7, 2, v);
    chk("R2 read with leading zeros returns word", {8'b0, v}, 16'h00FF);
  endtask

  task automatic t_write_status();
    logic [DW-1:0] v;
    ext_cmd(2'b11);
    select_dev(); send_cmd(2'b01, 9'h1A5); send_word(8'h96, DW);
    sel = 1'b0; sdin = 1'b0; wt(20);
    sel = 1'b1; wt(6);
    chk("R9 status low while programming", {14'b0, sdout_en, sdout}, 16'b10);
    wt(350);
    chk("R8 still busy before cycle end", {14'b0, sdout_en, sdout}, 16'b10);
    wt(50);
    chk("R8 ready after cycle end", {14'b0, sdout_en, sdout}, 16'b11);
    sel = 1'b0; wt(6);
    chk("R9 released on deselect", {15'b0, sdout_en}, 16'b0);
    wt(14);
    read_word(9'h1A5, 0, v);
    chk("R5 word written", {8'b0, v}, 16'h0096);
  endtask

  task automatic t_autoclear();
    logic [DW-1:0] v;
    write_word(9'h1A5, 8'h41);
    read_word(9'h1A5, 0, v);
    chk("R5 overwrite without erase", {8'b0, v}, 16'h0041);
  endtask

  task automatic t_busy_ignore();
    logic [DW-1:0] v;
    select_dev(); send_cmd(2'b01, 9'd3); send_word(8'h55, DW);
    sel = 1'b0; sdin = 1'b0; wt(20);
    sel = 1'b1; wt(6);
    chk("R10 status at select during cycle", {14'b0, sdout_en, sdout}, 16'b10);
    send_cmd(2'b11, 9'h1A5);
    chk("R10 command during cycle gives only status", {14'b0, sdout_en, sdout}, 16'b10);
    sel = 1'b0; sdin = 1'b0; wt(320);
    expect_idle("R10 ignored erase started no cycle");
    read_word(9'h1A5, 0, v);
    chk("R10 ignored erase left word", {8'b0, v}, 16'h0041);
    read_word(9'd3, 0, v);
    chk("R5 second word written", {8'b0, v}, 16'h0055);
  endtask

  task automatic t_erase();
    logic [DW-1:0] v;
    select_dev(); send_cmd(2'b11, 9'h1A5); deselect_dev(); wt(PROG + 50);
    read_word(9'h1A5, 0, v);
    chk("R6 erased word all ones", {8'b0, v}, 16'h00FF);
  endtask

  task automatic t_protect();
    logic [DW-1:0] v;
    ext_cmd(2'b00);
    select_dev(); send_cmd(2'b01, 9'd3); send_word(8'hAA, DW); deselect_dev();
    expect_idle("R7 protected write started no cycle");
    select_dev(); send_cmd(2'b11, 9'd3); deselect_dev();
    expect_idle("R7 protected erase started no cycle");
    read_word(9'd3, 0, v);
    chk("R7 protected word unchanged", {8'b0, v}, 16'h0055);
    ext_cmd(2'b10);
    ext_cmd(2'b01);
    select_dev(); send_cmd(2'b01, 9'd3); send_word(8'hAA, DW); deselect_dev();
    expect_idle("R3 patterns 10 and 01 did not enable");
    ext_cmd(2'b11);
    write_word(9'd3, 8'hAA);
    read_word(9'd3, 0, v);
    chk("R3 pattern 11 enabled writes", {8'b0, v}, 16'h00AA);
  endtask

  task automatic t_incomplete();
    logic [DW-1:0] v;
    select_dev(); send_cmd(2'b01, 9'd3); send_word(8'h0F, 4); deselect_dev();
    expect_idle("R12 short write started no cycle");
    read_word(9'd3, 0, v);
    chk("R12 short write left word", {8'b0, v}, 16'h00AA);
  endtask

  task automatic t_fast_reselect();
    logic [DW-1:0] v;
    logic b;
    select_dev();
    sel = 1'b0; wt(2);
    sel = 1'b1; wt(4);
    send_cmd(2'b10, 9'd3);
    chk("R11 early select ignores read", {15'b0, sdout_en}, 16'b0);
    take_bit(b);
    chk("R11 early select keeps output released", {15'b0, sdout_en}, 16'b0);
    deselect_dev();
    read_word(9'd3, 0, v);
    chk("R11 normal select after proper deselect", {8'b0, v}, 16'h00AA);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset();
    t_write_status();
    t_autoclear();
    t_busy_ignore();
    t_erase();
    t_protect();
    t_incomplete();
    t_fast_reselect();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule